// File: doc/BRIEF.md
# Auto-Advancing Glyph ROM Reader

This block sits between a CPU bus and a character ROM that stores each glyph as 32 consecutive bytes. A CPU read anywhere in the 4 KiB window at 0x5000-0x5FFF picks a glyph from the low twelve address bits. The byte within that glyph comes from a hidden five-bit position counter, not from the address. Repeated reads of the same address therefore walk through the glyph one byte per read.

The counter steps once for each completed read in the window and wraps from 31 back to 0. Software puts the counter back at the start of a glyph by reading a control address, 0x40B0. That read returns zero. A write to the same control address latches data bit 0 as a page select flag, which the block drives out for the rest of the system to use. The ROM address is combinational from the CPU address and the counter, so the ROM data can flow back as read data in the same cycle.

Top module: `glyph_rom_reader`

## Requirements
- R1: During a read in the window 0x5000-0x5FFF, `rom_addr` equals CPU address bits [11:0] in bits [16:5] and the position counter in bits [4:0].
- R2: Each read strobe in the window advances the position counter by one at the next clock edge. The counter wraps from 31 to 0.
- R3: A read strobe at 0x40B0 returns 0x00 on `cpu_rdata` and sets the position counter to 0 at the next clock edge.
- R4: A write strobe at 0x40B0 stores `cpu_wdata` bit 0 in `page_sel` at the next clock edge. Other data bits are ignored.
- R5: After reset, `page_sel` is 0 and the position counter is 0.
- R6: Writes to any address, and reads outside both the window and 0x40B0, leave the position counter unchanged. Writes to addresses other than 0x40B0 leave `page_sel` unchanged.
- R7: `cpu_rdata` equals `rom_data` during a read in the window. It is 0xFF for a read at any address other than the window and 0x40B0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| rom_addr | output | 17 | ROM byte address, glyph and position |
| rom_data | input | 8 | ROM byte at `rom_addr` |
| page_sel | output | 1 | Page select flag |

## Verification
A position counter that has drifted cannot be seen directly. It shows up in the low five bits of `rom_addr`, and so in the wrong glyph byte on `cpu_rdata`, on the very next window read after the fault. A skipped or doubled increment is caught within one read. A missed rewind is caught on the first read after 0x40B0. A wrap fault shows up only after 32 consecutive reads of one glyph. A bad page bit is visible on `page_sel` one cycle after the control write.

// File: rtl/glyph_rom_reader.sv
module glyph_rom_reader #(
  parameter int GLYPH_W = 12,
  parameter int POS_W   = 5,
  parameter int DW      = 8,
  parameter logic [15:0] WIN_BASE = 16'h5000,
  parameter logic [15:0] CTRL_ADR = 16'h40B0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              cpu_addr,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [DW-1:0]            cpu_wdata,
  output logic [DW-1:0]            cpu_rdata,
  output logic [GLYPH_W+POS_W-1:0] rom_addr,
  input  logic [DW-1:0]            rom_data,
  output logic                     page_sel
);
  localparam int AW = GLYPH_W + POS_W;

  logic [POS_W-1:0] pos;
  logic in_win, at_ctrl;

  assign in_win  = cpu_addr[15:GLYPH_W] == WIN_BASE[15:GLYPH_W];
  assign at_ctrl = cpu_addr == CTRL_ADR;
  assign rom_addr = {cpu_addr[GLYPH_W-1:0], pos};
  assign cpu_rdata = in_win ? rom_data : (at_ctrl ? '0 : '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      page_sel <= 1'b0;
    end else begin
      if (cpu_rd && at_ctrl)     pos <= '0;
      else if (cpu_rd && in_win) pos <= pos + 1'b1;
      if (cpu_wr && at_ctrl)     page_sel <= cpu_wdata[0];
    end
  end

  p_glyph_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && in_win |-> rom_addr[AW-1:POS_W] == cpu_addr[GLYPH_W-1:0]);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && in_win |=> rom_addr[POS_W-1:0] == $past(rom_addr[POS_W-1:0]) + 1'b1);
  p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && at_ctrl |=> rom_addr[POS_W-1:0] == '0);
  p_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && at_ctrl |=> page_sel == $past(cpu_wdata[0]));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && (in_win || at_ctrl)) |=> $stable(rom_addr[POS_W-1:0]));
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && at_ctrl) |=> $stable(page_sel));
endmodule

// File: tb/glyph_rom_reader_tb.sv
module glyph_rom_reader_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  data;
    logic [16:0] addr;
    logic        chk_addr;
    string       req;
  } exp_t;

  logic clk = 0, rst_n = 0, cpu_rd = 0, cpu_wr = 0, page_sel;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, cpu_rdata, rom_data;
  logic [16:0] rom_addr;
  int checks = 0, fails = 0, m_pos = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_fn(logic [16:0] a);
    return 8'((a * 7) ^ (a >> 9));
  endfunction
  assign rom_data = rom_fn(rom_addr);

  glyph_rom_reader dut_i (.clk, .rst_n, .cpu_addr, .cpu_rd, .cpu_wr,
    .cpu_wdata, .cpu_rdata, .rom_addr, .rom_data, .page_sel);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, string req);
    exp_t e;
    e.req = req;
    e.chk_addr = 0;
    e.addr = '0;
    if (a[15:12] == 4'h5) begin
      e.addr = {a[11:0], 5'(m_pos)};
      e.data = rom_fn(e.addr);
      e.chk_addr = 1;
      m_pos = (m_pos + 1) % 32;
    end else if (a == 16'h40B0) begin
      e.data = 8'h00;
      m_pos = 0;
    end else begin
      e.data = 8'hFF;
    end
    @(posedge clk); #1;
    cpu_addr = a; cpu_rd = 1;
    q.push_back(e);
    @(posedge clk); #1;
    cpu_rd = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, logic exp_page, string req);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(posedge clk); #1;
    cpu_wr = 0;
    chk(page_sel === exp_page, req, page_sel, exp_page);
  endtask

  always @(negedge clk) if (cpu_rd) begin
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "queue", 0, 1);
    end else begin
      e = q.pop_front();
      chk(cpu_rdata === e.data, e.req, cpu_rdata, e.data);
      if (e.chk_addr) chk(rom_addr === e.addr, e.req, rom_addr, e.addr);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(page_sel === 1'b0, "R5", page_sel, 0);
    rd(16'h5003, "R5 first read at position 0");
    rd(16'h5003, "R1 R2 R7");
    rd(16'h5003, "R1 R2 R7");
    wr(16'h40B0, 8'h01, 1'b1, "R4 set");
    wr(16'h40B0, 8'hFE, 1'b0, "R4 bit0 only");
    wr(16'h40B0, 8'h03, 1'b1, "R4 set again");
    wr(16'h5000, 8'h00, 1'b1, "R6 window write no effect on page");
    wr(16'h40B1, 8'h00, 1'b1, "R6 near-control write");
    rd(16'h4080, "R7 other read FF");
    rd(16'h6000, "R7 other read FF");
    rd(16'h5FFF, "R6 position held");
    rd(16'h40B0, "R3 control read 0");
    rd(16'h5010, "R3 rewound");
    rd(16'h40B0, "R3 control read 0");
    for (int i = 0; i < 34; i++) rd(16'h5ABC, "R2 wrap");
    rd(16'h4FFF, "R7 below window");
    rd(16'h5001, "R1 after outside read");
    @(posedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule